// File: doc/BRIEF.md
# UART Modem Loopback Status Generator

This block is the modem-line part of an 8250-style serial controller. It holds the modem control value written by the host: data-terminal-ready, request-to-send, two general outputs and a loopback enable. From these it builds the modem status byte. The upper nibble of that byte carries the four line states. The lower nibble carries sticky change flags, and any set flag raises a modem-status interrupt request.

When loopback is enabled, the line states come from the control outputs instead of the external pins. Every byte the host writes for transmission is also copied into the receive path in the same cycle. When loopback is off, the line states follow the external modem inputs after a synchroniser.

The block also watches request-to-send. A control write that turns this bit on emits a one-cycle pulse, so that an attached device, such as a pointing device, can answer with its identification bytes.

Top module: `uart_modem_loop`

## Requirements
- R1: After reset, `stat_q` is 0x00, `msi_req` and `rts_rise` are low, and the four control outputs are low.
- R2: While control bit 4 (loopback) is set, status bit 7 follows control bit 3, bit 6 follows control bit 2, bit 5 follows control bit 0 and bit 4 follows control bit 1. The status reflects a control write on the second rising edge after the write is presented.
- R3: A change between consecutive line samples sets a sticky flag: status bit 0 for bit 4 (CTS), bit 1 for bit 5 (DSR) and bit 3 for bit 7 (DCD).
- R4: Status bit 2 is set only when bit 6 (RI) goes from 1 to 0. A rise of RI sets no flag.
- R5: Flags accumulate until a cycle with `stat_rd` high clears them. A change detected on that same edge still sets its flag.
- R6: `msi_req` is high exactly while at least one of status bits 3:0 is set.
- R7: A control write that sets bit 1 while it was clear raises `rts_rise` for exactly one cycle, on the edge that stores the write. A write that leaves bit 1 set gives no pulse.
- R8: While loopback is set, `tx_we` gives `rx_push` high in the same cycle with `rx_data` equal to `tx_data`. With loopback clear, `rx_push` stays low.
- R9: With loopback clear, status bits 7,6,5,4 follow `ext_dcd`, `ext_ri`, `ext_dsr`, `ext_cts` after SYNC_STAGES+1 rising edges, with the same flag rules. With loopback set, these inputs have no effect on the status.
- R10: `dtr_o`, `rts_o`, `out1_o` and `out2_o` show control bits 0, 1, 2 and 3 one edge after a write. Write bits 7:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Modem control write strobe |
| ctl_wdata | input | 8 | Modem control write value |
| stat_rd | input | 1 | Status read strobe; clears the change flags |
| stat_q | output | 8 | Modem status: line states in 7:4, flags in 3:0 |
| msi_req | output | 1 | Modem-status interrupt request |
| rts_rise | output | 1 | One-cycle pulse when request-to-send is switched on |
| dtr_o | output | 1 | Data-terminal-ready output |
| rts_o | output | 1 | Request-to-send output |
| out1_o | output | 1 | General output 1 |
| out2_o | output | 1 | General output 2 |
| tx_we | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| rx_push | output | 1 | Push strobe into the receive buffer (loopback echo) |
| rx_data | output | 8 | Byte pushed into the receive buffer |
| ext_cts | input | 1 | External clear-to-send, asynchronous |
| ext_dsr | input | 1 | External data-set-ready, asynchronous |
| ext_ri | input | 1 | External ring indicator, asynchronous |
| ext_dcd | input | 1 | External carrier detect, asynchronous |

## Verification
A wrong stored line sample shows up at the ports in two ways. The upper status nibble is wrong, and a spurious or missing change flag appears, together with a wrong `msi_req`, on the edge after the bad sample is taken. A lost or stuck flag shows as an interrupt request that stays high after a status read, or one that never appears. A bad copy of the previous request-to-send value shows as a missing or doubled `rts_rise` in the cycle right after the write. Each of these is visible within one or two cycles of the stimulus, so the bench samples at those exact cycles.

// File: rtl/uml_pkg.sv
package uml_pkg;

    localparam int CTL_W    = 5;
    localparam int LOOP_BIT = 4;
    localparam int RTS_BIT  = 1;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } modem_lines_t;

    typedef struct packed {
        logic dcd_chg;
        logic ri_trail;
        logic dsr_chg;
        logic cts_chg;
    } modem_delta_t;

    // Cross-map control outputs onto status inputs for loopback
    function automatic modem_lines_t lines_from_ctl(input logic [3:0] c);
        modem_lines_t l;
        l.dcd = c[3];
        l.ri  = c[2];
        l.dsr = c[0];
        l.cts = c[1];
        return l;
    endfunction

    function automatic modem_delta_t detect_delta(input modem_lines_t prev,
                                                  input modem_lines_t cur);
        modem_delta_t d;
        d.dcd_chg  = prev.dcd ^ cur.dcd;
        d.ri_trail = prev.ri & ~cur.ri;
        d.dsr_chg  = prev.dsr ^ cur.dsr;
        d.cts_chg  = prev.cts ^ cur.cts;
        return d;
    endfunction

endpackage

// File: rtl/uml_sync.sv
module uml_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[i] <= '0;
                    else     stage[i] <= stage[i-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/uml_ctl_reg.sv
module uml_ctl_reg
    import uml_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              rts_pulse
);
    logic rise_now;

    assign rise_now = we && wdata[RTS_BIT] && !ctl_q[RTS_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '0;
            rts_pulse <= 1'b0;
        end else begin
            if (we) ctl_q <= wdata[CTL_W-1:0];
            rts_pulse <= rise_now;
        end
    end
endmodule

// File: rtl/uml_status.sv
module uml_status
    import uml_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  modem_lines_t src,
    input  logic         clr,
    output modem_lines_t lines_q,
    output modem_delta_t delta_q
);
    modem_delta_t chg;
    modem_delta_t delta_n;

    always_comb begin
        chg     = detect_delta(lines_q, src);
        delta_n = (clr ? modem_delta_t'('0) : delta_q) | chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lines_q <= '0;
            delta_q <= '0;
        end else begin
            lines_q <= src;
            delta_q <= delta_n;
        end
    end
endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
    import uml_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    input  logic              stat_rd,
    output logic [7:0]        stat_q,
    output logic              msi_req,
    output logic              rts_rise,
    output logic              dtr_o,
    output logic              rts_o,
    output logic              out1_o,
    output logic              out2_o,
    input  logic              tx_we,
    input  logic [DATA_W-1:0] tx_data,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    input  logic              ext_cts,
    input  logic              ext_dsr,
    input  logic              ext_ri,
    input  logic              ext_dcd
);
    logic [CTL_W-1:0] ctl_q;
    logic [3:0]       ext_sync;
    modem_lines_t     ext_lines;
    modem_lines_t     src_lines;
    modem_lines_t     lines_q;
    modem_delta_t     delta_q;
    logic             loop_on;

    uml_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .ctl_q    (ctl_q),
        .rts_pulse(rts_rise)
    );

    uml_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({ext_dcd, ext_ri, ext_dsr, ext_cts}),
        .q  (ext_sync)
    );

    assign ext_lines = modem_lines_t'(ext_sync);
    assign loop_on   = ctl_q[LOOP_BIT];
    assign src_lines = loop_on ? lines_from_ctl(ctl_q[3:0]) : ext_lines;

    uml_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .src    (src_lines),
        .clr    (stat_rd),
        .lines_q(lines_q),
        .delta_q(delta_q)
    );

    assign stat_q  = {lines_q, delta_q};
    assign msi_req = |delta_q;

    assign dtr_o  = ctl_q[0];
    assign rts_o  = ctl_q[1];
    assign out1_o = ctl_q[2];
    assign out2_o = ctl_q[3];

    assign rx_push = tx_we && loop_on;
    assign rx_data = tx_data;
endmodule

// File: rtl/uart_modem_loop_chk.sv
module uart_modem_loop_chk (
    input logic       clk,
    input logic       rst,
    input logic       stat_rd,
    input logic [7:0] stat_q,
    input logic       msi_req,
    input logic       rts_rise,
    input logic       rts_o,
    input logic [4:0] ctl_q
);
    p_map_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_q[4] |=> stat_q[7:4] == {$past(ctl_q[3]), $past(ctl_q[2]),
                                     $past(ctl_q[0]), $past(ctl_q[1])});

    p_ri_trail_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q[2]) |-> ($past(stat_q[6]) && !stat_q[6]));

    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> (stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0]));

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> (!msi_req || stat_q[7:4] != $past(stat_q[7:4])));

    p_pulse_len_r7: assert property (@(posedge clk) disable iff (rst)
        rts_rise |=> !rts_rise);

    p_pulse_edge_r7: assert property (@(posedge clk) disable iff (rst)
        rts_rise |-> (rts_o && !$past(rts_o)));
endmodule

bind uart_modem_loop uart_modem_loop_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .stat_rd (stat_rd),
    .stat_q  (stat_q),
    .msi_req (msi_req),
    .rts_rise(rts_rise),
    .rts_o   (rts_o),
    .ctl_q   (ctl_q)
);

// File: tb/uart_modem_loop_test.sv
module uart_modem_loop_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       stat_rd = 1'b0;
    logic [7:0] stat_q;
    logic       msi_req, rts_rise, dtr_o, rts_o, out1_o, out2_o;
    logic       tx_we = 1'b0;
    logic [7:0] tx_data = '0;
    logic       rx_push;
    logic [7:0] rx_data;
    logic       ext_cts = 0, ext_dsr = 0, ext_ri = 0, ext_dcd = 0;

    int errors = 0;
    int checks = 0;
    logic seen_rts;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_modem_loop uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .stat_rd(stat_rd), .stat_q(stat_q), .msi_req(msi_req),
        .rts_rise(rts_rise), .dtr_o(dtr_o), .rts_o(rts_o),
        .out1_o(out1_o), .out2_o(out2_o), .tx_we(tx_we), .tx_data(tx_data),
        .rx_push(rx_push), .rx_data(rx_data), .ext_cts(ext_cts),
        .ext_dsr(ext_dsr), .ext_ri(ext_ri), .ext_dcd(ext_dcd)
    );

    // {control write, expected status, expected rts pulse}
    localparam logic [16:0] VEC [8] = '{
        {8'h10, 8'h00, 1'b0},
        {8'h13, 8'h33, 1'b1},
        {8'h1C, 8'hCB, 1'b0},
        {8'h18, 8'h84, 1'b0},
        {8'h11, 8'h2A, 1'b0},
        {8'h11, 8'h20, 1'b0},
        {8'h1F, 8'hF9, 1'b1},
        {8'h10, 8'h0F, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write at one edge, return after the status edge that follows
    task automatic write_ctl(input logic [7:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
        seen_rts = rts_rise;
        @(negedge clk);
    endtask

    task automatic read_clear();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (5000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
            begin : body
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                // R1 reset state
                chk("R1 stat", stat_q, 8'h00);
                chk("R1 irq", msi_req, 1'b0);
                chk("R1 pulse", rts_rise, 1'b0);
                chk("R1 outs", {out2_o, out1_o, rts_o, dtr_o}, 4'h0);

                // R2 R3 R4 R6 R7 R10: loopback vectors
                for (int i = 0; i < 8; i++) begin
                    write_ctl(VEC[i][16:9]);
                    chk("R2/R3/R4 stat", stat_q, VEC[i][8:1]);
                    chk("R6 irq", msi_req, |VEC[i][4:1]);
                    chk("R7 pulse", seen_rts, VEC[i][0]);
                    chk("R10 outs", {out2_o, out1_o, rts_o, dtr_o}, VEC[i][12:9]);
                    if (i != 7) read_clear();
                end

                // R5: read on the same edge as a new change
                @(negedge clk);
                ctl_we = 1'b1;
                ctl_wdata = 8'h12;
                @(negedge clk);
                ctl_we = 1'b0;
                chk("R7 pulse overlap", rts_rise, 1'b1);
                stat_rd = 1'b1;
                @(negedge clk);
                stat_rd = 1'b0;
                chk("R5 clear+new", stat_q, 8'h11);
                read_clear();
                chk("R5 cleared", stat_q, 8'h10);
                chk("R6 irq low", msi_req, 1'b0);

                // R7: rewrite with RTS already set
                write_ctl(8'h12);
                chk("R7 no pulse", seen_rts, 1'b0);

                // R8: echo in loopback
                tx_we = 1'b1;
                tx_data = 8'hA5;
                #1;
                chk("R8 push", rx_push, 1'b1);
                chk("R8 data", rx_data, 8'hA5);
                @(negedge clk);
                tx_we = 1'b0;

                // leave loopback (cts 1->0 seen), then no echo
                write_ctl(8'h02);
                chk("R3 leave loop", stat_q, 8'h01);
                read_clear();
                tx_we = 1'b1;
                tx_data = 8'h3C;
                #1;
                chk("R8 no push", rx_push, 1'b0);
                @(negedge clk);
                tx_we = 1'b0;

                // R9: external lines
                ext_cts = 1'b1;
                ext_dcd = 1'b1;
                wait_cycles(4);
                chk("R9 ext cts dcd", stat_q, 8'h99);
                ext_ri = 1'b1;
                wait_cycles(4);
                chk("R4 ri rise no flag", stat_q, 8'hD9);
                read_clear();
                ext_ri = 1'b0;
                wait_cycles(4);
                chk("R4 ri trail", stat_q, 8'h94);
                read_clear();

                // R9: inputs ignored in loopback
                write_ctl(8'h10);
                chk("R9 enter loop", stat_q, 8'h09);
                read_clear();
                ext_dsr = 1'b1;
                ext_cts = 1'b0;
                wait_cycles(4);
                chk("R9 ignored", stat_q, 8'h00);
                chk("R9 no irq", msi_req, 1'b0);

                disable watchdog;
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule